// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets an external host read and write a bank of byte-wide registers through a four-signal or three-signal serial link. Each transfer opens with a command byte that carries the transfer direction, an auto-increment flag and a 6-bit register address. One or more data bytes follow. On writes the port issues one write strobe per received byte. On reads it fetches each byte from the bank and shifts it out MSB first.

The serial pins are oversampled in the system clock domain. Each half of the serial clock must therefore last at least four system clock cycles. The serial clock idles high. The port samples input data on its rising edges and changes output data on its falling edges. Chip select is active low.

A single mode input chooses four-wire operation, where read data goes out on a separate output pin, or three-wire operation, where read data is driven back onto the shared data line. In three-wire mode the pad feeds the shared line into the data input. The register bank answers a read strobe with data on `reg_rdata_i` one system cycle later. The port always fetches one byte ahead of the host, so a read burst ends with one unused read strobe.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, both output enables are low and neither register strobe is asserted.
- R2: A command byte whose first bit (bit 7) is 0 starts a write. Each following complete data byte produces exactly one one-cycle `reg_wr_en_o` pulse, with `reg_wdata_o` holding the byte and `reg_addr_o` holding the current address. A read strobe and a write strobe never occur in the same cycle.
- R3: A command byte whose bit 7 is 1 starts a read. The byte at the commanded address is presented MSB first on `spi_sdo_o`. Each bit changes on a falling serial clock edge and is valid at the following rising edge.
- R4: Command bit 6 set to 1 makes the address step by one after each data byte. When bit 6 is 0, every byte of the burst uses the same address. Bits 5 to 0 carry the starting address, MSB first.
- R5: During auto-increment, the address wraps from 63 to 0.
- R6: Chip select going high discards any partial byte and returns the port to the command phase. When chip select rises in the same sampled cycle as the eighth rising clock edge of a byte, the abort wins and no strobe is issued for that byte.
- R7: Both output enables are low whenever chip select is high, and throughout the command phase and data phase of a write.
- R8: During the data phase of a read, `spi_sdo_oe_o` is high when `three_wire_i` is 0 and `spi_sdio_oe_o` is high when `three_wire_i` is 1. The other enable stays low.
- R9: A burst of N data bytes uses 8 + 8N clock pulses and yields exactly N write strobes (for writes) or N bytes of read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_wire_i | input | 1 | 1 selects three-wire mode, 0 selects four-wire mode |
| spi_sclk_i | input | 1 | Serial clock from the host, idles high |
| spi_csn_i | input | 1 | Active-low chip select from the host |
| spi_sdi_i | input | 1 | Serial data input (the shared line in three-wire mode) |
| spi_sdo_o | output | 1 | Serial read data |
| spi_sdo_oe_o | output | 1 | Drive enable for the separate data-out pin |
| spi_sdio_oe_o | output | 1 | Drive enable for the shared data line |
| reg_wr_en_o | output | 1 | One-cycle register write strobe |
| reg_rd_en_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 6 | Register address for the strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid one cycle after the read strobe |

## Verification
A chip-select release and the completing rising clock edge of a data byte can land in the same sampled cycle. When they do, the byte-complete logic and the abort logic both want to act. The bench provokes this by raising chip select and the serial clock on the same system clock edge after seven data bits of a write. It judges the outcome in two ways: no write strobe appears, and a later read of the target address returns its old value. A second collision, an address update that wraps 63 to 0 in the same cycle as a strobe, is driven by bursts that start at address 62.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } xfer_phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic sdi_s
);
  localparam int SW = 3 * STAGES;
  localparam logic [2:0] IDLE_PINS = 3'b110;

  logic [SW-1:0] chain_q;
  logic          sclk_prev_q;
  logic [2:0]    cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q     <= {STAGES{IDLE_PINS}};
      sclk_prev_q <= 1'b1;
    end else begin
      chain_q     <= {chain_q[SW-4:0], sclk_i, csn_i, sdi_i};
      sclk_prev_q <= cur[2];
    end
  end

  assign cur       = chain_q[SW-1 -: 3];
  assign sclk_rise = cur[2] & ~sclk_prev_q;
  assign sclk_fall = ~cur[2] & sclk_prev_q;
  assign cs_idle   = cur[1];
  assign sdi_s     = cur[0];

  p_edges_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sclk_fall));
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              cs_idle,
  input  logic              sdi_s,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              read_active
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  xfer_phase_e       phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-2:0] shift_q;
  logic              rw_q;
  logic              inc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] next_addr;
  logic [DATA_W-1:0] full_byte;
  logic              byte_done;

  assign full_byte = {shift_q, sdi_s};
  assign byte_done = sclk_rise & ~cs_idle & (cnt_q == LAST_BIT);
  assign next_addr = inc_q ? addr_q + 1'b1 : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      cnt_q     <= '0;
      shift_q   <= '0;
      rw_q      <= 1'b0;
      inc_q     <= 1'b0;
      addr_q    <= '0;
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      if (cs_idle) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        rw_q    <= 1'b0;
      end else if (sclk_rise) begin
        shift_q <= full_byte[DATA_W-2:0];
        cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
        if (byte_done) begin
          if (phase_q == PH_CMD) begin
            phase_q   <= PH_DATA;
            rw_q      <= full_byte[DATA_W-1];
            inc_q     <= full_byte[DATA_W-2];
            addr_q    <= full_byte[ADDR_W-1:0];
            reg_addr  <= full_byte[ADDR_W-1:0];
            reg_rd_en <= full_byte[DATA_W-1];
          end else if (!rw_q) begin
            reg_wr_en <= 1'b1;
            reg_wdata <= full_byte;
            reg_addr  <= addr_q;
            addr_q    <= next_addr;
          end else begin
            reg_rd_en <= 1'b1;
            reg_addr  <= next_addr;
            addr_q    <= next_addr;
          end
        end
      end
    end
  end

  assign read_active = (phase_q == PH_DATA) & rw_q;

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, reg_rd_en}));
  p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && !inc_q) |=> $stable(addr_q));
  p_addr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase_q == PH_DATA && inc_q && addr_q == ADDR_TOP) |=> (addr_q == '0));
  p_abort_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (cnt_q == '0 && phase_q == PH_CMD && !reg_wr_en));
endmodule

// File: rtl/spi_dout_drv.sv
module spi_dout_drv #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              sclk_fall,
  input  logic              load,
  input  logic [DATA_W-1:0] rdata,
  input  logic              read_active,
  output logic              dout,
  output logic              oe
);
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      dout    <= 1'b0;
      oe      <= 1'b0;
    end else if (cs_idle) begin
      dout <= 1'b0;
      oe   <= 1'b0;
    end else begin
      oe <= read_active;
      if (load) begin
        shift_q <= rdata;
      end else if (sclk_fall && read_active) begin
        dout    <= shift_q[DATA_W-1];
        shift_q <= {shift_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  p_oe_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !oe);
  p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_idle && !sclk_fall && $past(!cs_idle)) |=> $stable(dout));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              three_wire_i,
  input  logic              spi_sclk_i,
  input  logic              spi_csn_i,
  input  logic              spi_sdi_i,
  output logic              spi_sdo_o,
  output logic              spi_sdo_oe_o,
  output logic              spi_sdio_oe_o,
  output logic              reg_wr_en_o,
  output logic              reg_rd_en_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic sclk_rise, sclk_fall, cs_idle, sdi_s;
  logic read_active, rd_load_q, drv_oe;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(spi_sclk_i), .csn_i(spi_csn_i), .sdi_i(spi_sdi_i),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .sdi_s(sdi_s)
  );

  spi_cmd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .cs_idle(cs_idle), .sdi_s(sdi_s),
    .reg_wr_en(reg_wr_en_o), .reg_rd_en(reg_rd_en_o),
    .reg_addr(reg_addr_o), .reg_wdata(reg_wdata_o),
    .read_active(read_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_load_q <= 1'b0;
    else        rd_load_q <= reg_rd_en_o;
  end

  spi_dout_drv #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .cs_idle(cs_idle), .sclk_fall(sclk_fall),
    .load(rd_load_q), .rdata(reg_rdata_i),
    .read_active(read_active),
    .dout(spi_sdo_o), .oe(drv_oe)
  );

  assign spi_sdo_oe_o  = drv_oe & ~three_wire_i;
  assign spi_sdio_oe_o = drv_oe &  three_wire_i;

  p_oe_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_sdo_oe_o && spi_sdio_oe_o));
  p_no_oe_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en_o |-> !(spi_sdo_oe_o || spi_sdio_oe_o));
endmodule

// File: tb/tb_spi_reg_port.sv
module tb_spi_reg_port;
  localparam int H = 8;
  localparam int NV = 8;
  // fields: mode, rw, inc, addr[5:0], nbytes[2:0], seed[7:0]
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 6'd5,  3'd3, 8'hA0},
    {1'b0, 1'b1, 1'b1, 6'd5,  3'd3, 8'h00},
    {1'b0, 1'b0, 1'b0, 6'd10, 3'd2, 8'h33},
    {1'b0, 1'b1, 1'b0, 6'd10, 3'd2, 8'h00},
    {1'b1, 1'b0, 1'b1, 6'd62, 3'd3, 8'hC0},
    {1'b1, 1'b1, 1'b1, 6'd62, 3'd3, 8'h00},
    {1'b1, 1'b1, 1'b0, 6'd6,  3'd1, 8'h00},
    {1'b0, 1'b0, 1'b0, 6'd63, 3'd1, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic three_wire = 1'b0;
  logic sclk = 1'b1;
  logic csn = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_oe, sdio_oe, wr_en, rd_en;
  logic [5:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata = 8'h00;
  logic [7:0] bank [64];
  logic [7:0] exp_mem [64];
  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  logic done = 1'b0;
  logic oe_a = 1'b0;
  logic oe_b = 1'b0;
  logic oe_bad = 1'b0;

  always #2.5 clk = ~clk;

  spi_reg_port dut (
    .clk(clk), .rst_n(rst_n), .three_wire_i(three_wire),
    .spi_sclk_i(sclk), .spi_csn_i(csn), .spi_sdi_i(sdi),
    .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe), .spi_sdio_oe_o(sdio_oe),
    .reg_wr_en_o(wr_en), .reg_rd_en_o(rd_en), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  initial for (int i = 0; i < 64; i++) begin bank[i] = 8'h00; exp_mem[i] = 8'h00; end

  always @(posedge clk) begin
    if (wr_en) begin bank[addr] <= wdata; wr_count <= wr_count + 1; end
    if (rd_en) rdata <= bank[addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: data set with falling clock, sampled just before rising
  task automatic spi_bit(input logic b, output logic r);
    sclk = 1'b0; sdi = b;
    wait_clk(H);
    r = sdo; oe_a = sdo_oe; oe_b = sdio_oe;
    sclk = 1'b1;
    wait_clk(H);
  endtask

  task automatic xfer(input logic [19:0] v);
    logic mode, rw, inc, r;
    logic [5:0] a;
    logic [2:0] n;
    logic [7:0] seed, cmd, got;
    int wc0;
    {mode, rw, inc, a, n, seed} = v;
    three_wire = mode;
    wc0 = wr_count;
    cmd = {rw, inc, a};
    csn = 1'b0;
    wait_clk(H);
    for (int b = 7; b >= 0; b--) spi_bit(cmd[b], r);
    for (int k = 0; k < int'(n); k++) begin
      got = 8'h00;
      oe_bad = 1'b0;
      for (int b = 7; b >= 0; b--) begin
        spi_bit(rw ? 1'b0 : 1'(seed >> b) ^ 1'b0 ? 1'(seed >> b) : 1'(seed >> b), r);
        got[b] = r;
        if (rw) begin
          if (oe_a !== ~mode || oe_b !== mode) oe_bad = 1'b1;
        end else if (oe_a || oe_b) oe_bad = 1'b1;
      end
      if (rw) begin
        chk("R3/R4/R5 read byte", got, exp_mem[a]);
        chk("R8 read oe per mode", oe_bad, 1'b0);
      end else begin
        exp_mem[a] = seed;
        chk("R7 oe low during write", oe_bad, 1'b0);
      end
      seed = seed + 8'd1;
      if (inc) a = a + 6'd1;
    end
    wait_clk(H);
    csn = 1'b1;
    wait_clk(2 * H);
    if (!rw) chk("R2/R9 write strobe count", wr_count - wc0, n);
    chk("R7 oe low after cs high", {sdo_oe, sdio_oe}, 2'b00);
  endtask

  initial begin
    logic r;
    logic [7:0] cmd;
    int wc0;
    wait_clk(4);
    chk("R1 reset oe", {sdo_oe, sdio_oe}, 2'b00);
    chk("R1 reset strobes", {wr_en, rd_en}, 2'b00);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1 idle after reset", {sdo_oe, sdio_oe, wr_en, rd_en}, 4'b0000);

    for (int i = 0; i < NV; i++) xfer(VEC[i]);

    // R6: partial command byte aborted
    three_wire = 1'b0;
    wc0 = wr_count;
    csn = 1'b0; wait_clk(H);
    for (int b = 7; b >= 4; b--) spi_bit(1'b1, r);
    csn = 1'b1; wait_clk(2 * H);
    // R6: write byte cut by chip select together with the final rising edge
    cmd = {1'b0, 1'b0, 6'd21};
    csn = 1'b0; wait_clk(H);
    for (int b = 7; b >= 0; b--) spi_bit(cmd[b], r);
    for (int b = 0; b < 7; b++) spi_bit(1'b1, r);
    sclk = 1'b0; sdi = 1'b1; wait_clk(H);
    sclk = 1'b1; csn = 1'b1;
    wait_clk(3 * H);
    chk("R6 no strobe on abort", wr_count - wc0, 0);
    xfer({1'b0, 1'b1, 1'b0, 6'd21, 3'd1, 8'h00});
    xfer({1'b0, 1'b1, 1'b1, 6'd0, 3'd1, 8'h00});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule